// File: doc/BRIEF.md
# Configurable Pad Cell

This block sits between core logic and a group of bidirectional chip pads. It has one path going out and one coming in, and each path has its own flip-flop and its own clock. On the way out, a static configuration word picks one of two sources for each lane: the live output data, or a copy of that data taken on the output clock. The chosen value can then be inverted. A per-lane tri-state enable, which also has an optional polarity flip, decides whether the cell drives the pad or leaves it at high impedance.

On the way in, the cell gives the core two views of the pad. One is combinational. The other is captured on the input clock. Both views follow the pad even while the cell is driving it, so the core can read back what it sends. One active-low global reset clears both flip-flops.

Two electrical choices are carried as configuration outputs and have no effect on the data paths: a fast or slow edge rate, and a weak pull-up meant for unused pads. All lanes share one configuration word. Each lane has its own data and its own enable.

Top module: `prog_pad_cell`

## Requirements
- R1: While `rstN` is low, both flip-flops hold zero. `inReg` reads all zeros, and a driving lane set to the registered source with no inversion puts 0 on the pad.
- R2: With `cfgVec` bit 0 at 0, the pad carries `outData` straight through. With bit 0 at 1, it carries the value of `outData` captured at the most recent rising edge of `outClk`.
- R3: With `cfgVec` bit 1 at 1, the value chosen by R2 is inverted before it reaches the pad.
- R4: A lane drives its pad only when its `outEn` bit XOR `cfgVec` bit 2 equals 1. Otherwise the lane is at high impedance, and a value driven from outside shows through.
- R5: `inDirect` always equals the pad. This includes the value the cell drives itself.
- R6: `inReg` takes the pad value on each rising edge of `inClk` and holds it between edges.
- R7: An `outClk` edge never changes `inReg`. An `inClk` edge never changes the output flip-flop.
- R8: `slewFast` equals `cfgVec` bit 3 and `pullUpEn` equals `cfgVec` bit 4. Neither changes any pad or input value.
- R9: Lanes are independent. In the same cycle, some lanes can drive while others are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| outClk | input | 1 | Clock for the output flip-flop |
| inClk | input | 1 | Clock for the input flip-flop |
| rstN | input | 1 | Global asynchronous reset, active low |
| cfgVec | input | 5 | Static configuration: [0] registered source, [1] invert data, [2] invert enable, [3] fast slew, [4] pull-up |
| outData | input | PAD_W | Data the core sends out |
| outEn | input | PAD_W | Per-lane tri-state enable before polarity |
| inDirect | output | PAD_W | Combinational copy of the pads |
| inReg | output | PAD_W | Pad values captured on `inClk` |
| slewFast | output | 1 | Edge-rate selection passed to the pad driver |
| pullUpEn | output | 1 | Weak pull-up request passed to the pad |
| pad | inout | PAD_W | Bidirectional pad nets |

## Verification
The assertions assume that `cfgVec` is constant between clock edges. They also assume that nothing outside the cell drives a lane while the cell's effective enable for that lane is high, because the loopback check relies on the cell winning the net. The stimulus only changes the configuration while both clocks are low. The external driver is released on every lane that the directed case expects the cell to drive.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  localparam int CFG_W    = 5;
  localparam int CFG_SRC  = 0;
  localparam int CFG_INVD = 1;
  localparam int CFG_INVE = 2;
  localparam int CFG_SLEW = 3;
  localparam int CFG_PULL = 4;

  typedef struct packed {
    logic selReg;
    logic invData;
    logic invEn;
  } dpStrobe_t;
endpackage

// File: rtl/iocell_ctrl.sv
module iocell_ctrl
  import iocell_pkg::*;
(
  input  logic [CFG_W-1:0] cfgVec,
  output dpStrobe_t        strobe,
  output logic             slewFast,
  output logic             pullUpEn
);
  always_comb begin
    strobe.selReg  = cfgVec[CFG_SRC];
    strobe.invData = cfgVec[CFG_INVD];
    strobe.invEn   = cfgVec[CFG_INVE];
  end

  assign slewFast = cfgVec[CFG_SLEW];
  assign pullUpEn = cfgVec[CFG_PULL];
endmodule

// File: rtl/iocell_dpath.sv
module iocell_dpath
  import iocell_pkg::*;
#(
  parameter int PAD_W = 4
) (
  input  logic             outClk,
  input  logic             inClk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PAD_W-1:0] outData,
  input  logic [PAD_W-1:0] outEn,
  output logic [PAD_W-1:0] inDirect,
  output logic [PAD_W-1:0] inReg,
  inout  wire  [PAD_W-1:0] pad
);
  localparam logic [PAD_W-1:0] ZERO_W = '0;

  logic [PAD_W-1:0] outQ;
  logic [PAD_W-1:0] srcVal;
  logic [PAD_W-1:0] drvVal;
  logic [PAD_W-1:0] drvEn;

  always_ff @(posedge outClk or negedge rstN) begin
    if (!rstN) outQ <= ZERO_W;
    else       outQ <= outData;
  end

  assign srcVal = strobe.selReg ? outQ : outData;
  assign drvVal = srcVal ^ {PAD_W{strobe.invData}};
  assign drvEn  = outEn ^ {PAD_W{strobe.invEn}};

  for (genvar lane = 0; lane < PAD_W; lane++) begin : g_lane
    assign pad[lane] = drvEn[lane] ? drvVal[lane] : 1'bz;
  end

  assign inDirect = pad;

  always_ff @(posedge inClk or negedge rstN) begin
    if (!rstN) inReg <= ZERO_W;
    else       inReg <= pad;
  end

  // R2: the output flop holds what outData was at the previous outClk edge
  a_r2_out_capture: assert property (@(posedge outClk) disable iff (!rstN)
    1'b1 |=> outQ == $past(outData));

  // R6: the input flop holds what the pad was at the previous inClk edge
  a_r6_in_capture: assert property (@(posedge inClk) disable iff (!rstN)
    1'b1 |=> inReg == $past(pad));

  // R5: every lane the cell drives reads back its own value
  a_r5_loopback: assert property (@(posedge outClk) disable iff (!rstN)
    (inDirect & drvEn) == (drvVal & drvEn));
endmodule

// File: rtl/prog_pad_cell.sv
module prog_pad_cell #(
  parameter int PAD_W = 4
) (
  input  logic                           outClk,
  input  logic                           inClk,
  input  logic                           rstN,
  input  logic [iocell_pkg::CFG_W-1:0]   cfgVec,
  input  logic [PAD_W-1:0]               outData,
  input  logic [PAD_W-1:0]               outEn,
  output logic [PAD_W-1:0]               inDirect,
  output logic [PAD_W-1:0]               inReg,
  output logic                           slewFast,
  output logic                           pullUpEn,
  inout  wire  [PAD_W-1:0]               pad
);
  import iocell_pkg::*;

  dpStrobe_t strobe;

  iocell_ctrl u_ctrl (
    .cfgVec   (cfgVec),
    .strobe   (strobe),
    .slewFast (slewFast),
    .pullUpEn (pullUpEn)
  );

  iocell_dpath #(.PAD_W(PAD_W)) u_dpath (
    .outClk   (outClk),
    .inClk    (inClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outData  (outData),
    .outEn    (outEn),
    .inDirect (inDirect),
    .inReg    (inReg),
    .pad      (pad)
  );

  // R3: a direct source with inversion and every lane driving shows ~outData
  a_r3_invert_direct: assert property (@(posedge outClk) disable iff (!rstN)
    (cfgVec[CFG_INVD] && !cfgVec[CFG_SRC] &&
     ((outEn ^ {PAD_W{cfgVec[CFG_INVE]}}) == {PAD_W{1'b1}}))
    |-> inDirect == ~outData);

  // R4: a direct source with no inversion and every lane driving shows outData
  a_r4_drive_direct: assert property (@(posedge outClk) disable iff (!rstN)
    (!cfgVec[CFG_INVD] && !cfgVec[CFG_SRC] &&
     ((outEn ^ {PAD_W{cfgVec[CFG_INVE]}}) == {PAD_W{1'b1}}))
    |-> inDirect == outData);
endmodule

// File: tb/tb_prog_pad_cell.sv
module tb_prog_pad_cell;
  localparam int CLK_PERIOD = 10;
  localparam int PAD_W = 4;

  logic outClk = 1'b0;
  logic inClk  = 1'b0;
  logic rstN   = 1'b0;
  logic [4:0] cfgVec = '0;
  logic [PAD_W-1:0] outData = '0;
  logic [PAD_W-1:0] outEn   = '0;
  logic [PAD_W-1:0] tbDrv   = '0;
  logic [PAD_W-1:0] tbVal   = '0;
  logic [PAD_W-1:0] inDirect;
  logic [PAD_W-1:0] inReg;
  logic slewFast;
  logic pullUpEn;
  wire  [PAD_W-1:0] pad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  for (genvar i = 0; i < PAD_W; i++) begin : g_ext
    assign pad[i] = tbDrv[i] ? tbVal[i] : 1'bz;
  end

  prog_pad_cell #(.PAD_W(PAD_W)) dut (
    .outClk(outClk), .inClk(inClk), .rstN(rstN), .cfgVec(cfgVec),
    .outData(outData), .outEn(outEn), .inDirect(inDirect), .inReg(inReg),
    .slewFast(slewFast), .pullUpEn(pullUpEn), .pad(pad)
  );

  task automatic check(string tag, logic [PAD_W-1:0] act, logic [PAD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseOut();
    #(CLK_PERIOD/2) outClk = 1'b1;
    #(CLK_PERIOD/2) outClk = 1'b0;
    #1;
  endtask

  task automatic pulseIn();
    #(CLK_PERIOD/2) inClk = 1'b1;
    #(CLK_PERIOD/2) inClk = 1'b0;
    #1;
  endtask

  task automatic testReset();
    rstN = 1'b0; tbDrv = '0; cfgVec = 5'b00001; outEn = 4'hF; outData = 4'hA;
    #2;
    check("R1 inReg in reset", inReg, 4'h0);
    check("R1 registered pad in reset", inDirect, 4'h0);
    pulseOut();
    check("R1 outClk ignored in reset", inDirect, 4'h0);
    rstN = 1'b1; #1;
  endtask

  task automatic testDirect();
    cfgVec = 5'b00000; outEn = 4'hF; tbDrv = '0; outData = 4'hA; #1;
    check("R2 direct A", inDirect, 4'hA);
    outData = 4'h5; #1;
    check("R2 direct 5", inDirect, 4'h5);
  endtask

  task automatic testRegSource();
    cfgVec = 5'b00001; outEn = 4'hF; tbDrv = '0; outData = 4'h9;
    pulseOut();
    check("R2 registered after edge", inDirect, 4'h9);
    outData = 4'h6; #1;
    check("R2 registered holds", inDirect, 4'h9);
    pulseIn();
    check("R7 inClk leaves output flop", inDirect, 4'h9);
    check("R6 inReg took driven pad", inReg, 4'h9);
  endtask

  task automatic testInvert();
    cfgVec = 5'b00010; outEn = 4'hF; tbDrv = '0; outData = 4'h3; #1;
    check("R3 inverted direct", inDirect, 4'hC);
    cfgVec = 5'b00011; outData = 4'h1;
    pulseOut();
    check("R3 inverted registered", inDirect, 4'hE);
  endtask

  task automatic testEnable();
    cfgVec = 5'b00000; outData = 4'hF; outEn = 4'h0; tbDrv = 4'hF; tbVal = 4'hA; #1;
    check("R4 released shows external", inDirect, 4'hA);
    cfgVec = 5'b00100; outEn = 4'hF; tbVal = 4'h5; #1;
    check("R4 enable inverted releases", inDirect, 4'h5);
    tbDrv = 4'h0; outEn = 4'h0; outData = 4'h6; #1;
    check("R4 enable inverted drives", inDirect, 4'h6);
    cfgVec = 5'b00000; outEn = 4'b0011; outData = 4'b0101;
    tbDrv = 4'b1100; tbVal = 4'b1000; #1;
    check("R9 mixed lanes", inDirect, 4'b1001);
  endtask

  task automatic testInReg();
    cfgVec = 5'b00000; outEn = 4'h0; tbDrv = 4'hF; tbVal = 4'h7;
    pulseIn();
    check("R6 capture external", inReg, 4'h7);
    check("R5 direct follows pad", inDirect, 4'h7);
    tbVal = 4'h2; #1;
    check("R6 holds between edges", inReg, 4'h7);
    check("R5 direct tracks change", inDirect, 4'h2);
    pulseOut();
    check("R7 outClk leaves inReg", inReg, 4'h7);
    pulseIn();
    check("R6 next capture", inReg, 4'h2);
  endtask

  task automatic testCfgOut();
    cfgVec = 5'b01000; #1;
    check("R8 slew fast", {3'b0, slewFast}, 4'h1);
    check("R8 pull-up off", {3'b0, pullUpEn}, 4'h0);
    check("R8 data unchanged by slew", inDirect, 4'h2);
    cfgVec = 5'b10000; #1;
    check("R8 pull-up on", {3'b0, pullUpEn}, 4'h1);
    check("R8 slew slow", {3'b0, slewFast}, 4'h0);
    check("R8 data unchanged by pull-up", inDirect, 4'h2);
  endtask

  task automatic testMidReset();
    cfgVec = 5'b00001; outEn = 4'hF; tbDrv = '0; outData = 4'hB;
    pulseOut();
    pulseIn();
    check("R6 capture before reset", inReg, 4'hB);
    rstN = 1'b0; #1;
    check("R1 reset clears output flop", inDirect, 4'h0);
    check("R1 reset clears inReg", inReg, 4'h0);
    rstN = 1'b1; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testDirect();
    testRegSource();
    testInvert();
    testEnable();
    testInReg();
    testCfgOut();
    testMidReset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule